// File: doc/BRIEF.md
# Daisy-Chained Serial Configuration Loader

This block receives the setup word of a configurable device over a three-wire serial link: a serial clock, a data bit and an active-low load enable. While the enable is low, each rising clock edge shifts one bit into a setup register of fixed length. A counter tracks how many bits have arrived. The counted bits are the accepted ones. Edges seen while the enable is high do not count.

When the last bit of the word has been taken, the register freezes and the block becomes transparent. Its active-low enable output then copies the enable input, and the serial data input drives the serial data output directly. Identical devices can therefore be wired in a chain: each device's data output feeds the next device's data input, and each enable output feeds the next enable input. One continuous bit stream then programs the whole chain, nearest device first. A low enable output from the last device shows that every device in the chain is loaded and ready for normal work.

The master reset is asserted asynchronously and released synchronously to the serial clock. It returns the block to the empty, unprogrammed state.

Top module: `cfgchain_loader`

## Requirements
- R1: While reset is held, and until the first accepted bit, the enable output is high, the data output is low and every bit of the setup register reads zero.
- R2: Bits are accepted on rising clock edges while the enable input is low. After LEN accepted bits, the first bit accepted sits at setup register bit LEN-1 and the last bit accepted sits at bit 0.
- R3: Clock edges that occur while the enable input is high change neither the setup register nor the number of bits counted.
- R4: Before the LEN-th bit has been accepted, the enable output is high whatever the enable input does.
- R5: Directly after the clock edge that accepts the LEN-th bit, the enable output is low, because the enable input is still low.
- R6: Once programmed, the enable output equals the enable input without any clock delay, in both directions.
- R7: Before programming completes, the data output stays low whatever the data input carries, so no bit reaches downstream devices early.
- R8: Once programmed, the data output equals the data input without any clock delay.
- R9: Once programmed, further accepted clock edges leave the setup register unchanged.
- R10: A reset applied partway through a load discards the partial word. A following load needs a full LEN accepted bits again and yields only the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial clock, rising edge active |
| rst_ni | input | 1 | Master reset, active low, asynchronous assert |
| sdi_i | input | 1 | Serial data input |
| sen_ni | input | 1 | Load enable input, active low |
| sdo_o | output | 1 | Serial data output toward the next device |
| sen_no | output | 1 | Enable output toward the next device, active low |
| cfg_o | output | LEN | Setup register contents |

## Verification
A counter that is off by one shows at the enable output on the very edge where the LEN-th bit should complete the load. The output falls one accepted edge too early or too late. The same fault shifts the setup word by one position, and that shows on the setup register outputs in that cycle. A register or counter that moves during disabled edges shows as a corrupted word or a misplaced completion edge, within the same load. A premature or missing programmed state shows immediately as data leaking to the data output, or as enable and data failing to track their inputs once the load is complete.

// File: rtl/cfgchain_pkg.sv
package cfgchain_pkg;

  typedef enum logic {
    LD_FILL = 1'b0,
    LD_PASS = 1'b1
  } ld_state_e;

  function automatic int unsigned cnt_width(input int unsigned len);
    return (len < 2) ? 1 : $clog2(len);
  endfunction

endpackage

// File: rtl/cfgchain_shreg.sv
module cfgchain_shreg #(
  parameter int unsigned LEN = 64
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           shift_i,
  input  logic           bit_i,
  input  logic           pass_i,
  output logic [LEN-1:0] q_o
);

  logic [LEN-1:0] q_d, q_q;

  always_comb begin
    q_d = q_q;
    if (shift_i) begin
      q_d = {q_q[LEN-2:0], bit_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= '0;
    end else if (shift_i) begin
      q_q <= q_d;
    end
  end

  assign q_o = q_q;

  p_hold_idle_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(q_q));

  p_frozen_after_load_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_i |=> $stable(q_q));

endmodule

// File: rtl/cfgchain_counter.sv
module cfgchain_counter
  import cfgchain_pkg::*;
#(
  parameter int unsigned LEN = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  output logic pass_o
);

  localparam int unsigned CW = cnt_width(LEN);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt_d, cnt_q;
  ld_state_e     st_d, st_q;
  logic          adv;

  assign adv = take_i && (st_q == LD_FILL);

  always_comb begin
    cnt_d = cnt_q;
    st_d  = st_q;
    if (adv) begin
      if (cnt_q == LAST) begin
        st_d  = LD_PASS;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      st_q  <= LD_FILL;
    end else if (adv) begin
      cnt_q <= cnt_d;
      st_q  <= st_d;
    end
  end

  assign pass_o = (st_q == LD_PASS);

  p_last_bit_completes_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !pass_o && cnt_q == LAST) |=> pass_o);

  p_count_idle_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_i |=> ($stable(cnt_q) && $stable(st_q)));

  p_no_early_pass_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pass_o && !(take_i && cnt_q == LAST)) |=> !pass_o);

  p_pass_sticky_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |=> pass_o);

endmodule

// File: rtl/cfgchain_route.sv
module cfgchain_route (
  input  logic pass_i,
  input  logic sdi_i,
  input  logic sen_ni,
  output logic sdo_o,
  output logic sen_no
);

  always_comb begin
    if (pass_i) begin
      sdo_o  = sdi_i;
      sen_no = sen_ni;
    end else begin
      sdo_o  = 1'b0;
      sen_no = 1'b1;
    end
  end

endmodule

// File: rtl/cfgchain_loader.sv
module cfgchain_loader #(
  parameter int unsigned LEN = 64
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           sdi_i,
  input  logic           sen_ni,
  output logic           sdo_o,
  output logic           sen_no,
  output logic [LEN-1:0] cfg_o
);

  logic [1:0] rst_sync_q;
  logic       rst_s_n;
  logic       pass;
  logic       take;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_s_n = rst_sync_q[1];
  assign take    = !sen_ni;

  cfgchain_counter #(.LEN(LEN)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_s_n),
    .take_i (take),
    .pass_o (pass)
  );

  cfgchain_shreg #(.LEN(LEN)) u_shreg (
    .clk_i   (clk_i),
    .rst_ni  (rst_s_n),
    .shift_i (take && !pass),
    .bit_i   (sdi_i),
    .pass_i  (pass),
    .q_o     (cfg_o)
  );

  cfgchain_route u_route (
    .pass_i (pass),
    .sdi_i  (sdi_i),
    .sen_ni (sen_ni),
    .sdo_o  (sdo_o),
    .sen_no (sen_no)
  );

  p_reset_quiet_r1 : assert property (@(posedge clk_i)
    !rst_s_n |-> (sen_no && !sdo_o));

endmodule

// File: tb/cfgchain_loader_tb.sv
module cfgchain_loader_tb;

  localparam int unsigned LEN = 8;

  logic           clk_i = 1'b0;
  logic           rst_ni;
  logic           sdi_i;
  logic           sen_ni;
  logic           sdo_o;
  logic           sen_no;
  logic [LEN-1:0] cfg_o;

  int checks = 0;
  int errors = 0;
  int seed_v = 7;

  always #4 clk_i = ~clk_i;

  cfgchain_loader #(.LEN(LEN)) u_dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sdi_i  (sdi_i),
    .sen_ni (sen_ni),
    .sdo_o  (sdo_o),
    .sen_no (sen_no),
    .cfg_o  (cfg_o)
  );

  task automatic chk(input bit ok, input string req, input logic [LEN-1:0] act,
                     input logic [LEN-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic rnd_bit();
    seed_v = seed_v * 1103515245 + 12345;
    return seed_v[16];
  endfunction

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    sen_ni = 1'b1;
    sdi_i  = 1'b1;
    #1;
    chk(sen_no == 1'b1, "R1 enable out in reset", LEN'(sen_no), LEN'(1));
    chk(sdo_o == 1'b0, "R1 data out in reset", LEN'(sdo_o), '0);
    chk(cfg_o == '0, "R1 register in reset", cfg_o, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
  endtask

  // one clock with given inputs; returns after the edge, outputs settled
  task automatic edge_with(input logic b, input logic en_n);
    @(negedge clk_i);
    sdi_i  = b;
    sen_ni = en_n;
    @(posedge clk_i);
    #2;
  endtask

  // load pattern p, first bit = p[LEN-1]; gaps of disabled edges in between
  task automatic load_word(input logic [LEN-1:0] p, input int gap_at);
    for (int j = 0; j < LEN; j++) begin
      if (j == gap_at) begin
        edge_with(rnd_bit(), 1'b1);
        chk(sen_no == 1'b1, "R4 enable out during gap", LEN'(sen_no), LEN'(1));
        chk(sdo_o == 1'b0, "R7 data out during gap", LEN'(sdo_o), '0);
      end
      edge_with(p[LEN-1-j], 1'b0);
      if (j < LEN - 1) begin
        chk(sen_no == 1'b1, "R4 enable out before last bit", LEN'(sen_no), LEN'(1));
        sdi_i = 1'b1;
        #1;
        chk(sdo_o == 1'b0, "R7 data out before load done", LEN'(sdo_o), '0);
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    sen_ni = 1'b1;
    sdi_i  = 1'b0;
    repeat (2) @(negedge clk_i);

    for (int p = 0; p < (1 << LEN); p++) begin
      logic [LEN-1:0] pw;
      pw = LEN'(p);
      do_reset();
      // R3: disabled edges before load change nothing
      edge_with(1'b1, 1'b1);
      chk(cfg_o == '0, "R3 register after disabled edge", cfg_o, '0);
      load_word(pw, p % (LEN + 1));
      chk(cfg_o == pw, "R2 loaded word", cfg_o, pw);
      chk(sen_no == 1'b0, "R5 enable out after last bit", LEN'(sen_no), '0);
      // R6: follows enable input both ways, no clock
      @(negedge clk_i);
      sen_ni = 1'b1;
      #1;
      chk(sen_no == 1'b1, "R6 enable out follows high", LEN'(sen_no), LEN'(1));
      sen_ni = 1'b0;
      #1;
      chk(sen_no == 1'b0, "R6 enable out follows low", LEN'(sen_no), '0);
      // R8/R9: pass-through and freeze
      for (int k = 0; k < 3; k++) begin
        logic b;
        b = rnd_bit();
        @(negedge clk_i);
        sdi_i  = b;
        sen_ni = 1'b0;
        #1;
        chk(sdo_o == b, "R8 data passes through", LEN'(sdo_o), LEN'(b));
        sdi_i = ~b;
        #1;
        chk(sdo_o == ~b, "R8 data passes through toggled", LEN'(sdo_o), LEN'(~b));
        @(posedge clk_i);
        #2;
        chk(cfg_o == pw, "R9 register frozen", cfg_o, pw);
      end
    end

    // R10: partial load then reset
    do_reset();
    for (int j = 0; j < 3; j++) edge_with(1'b1, 1'b0);
    do_reset();
    chk(cfg_o == '0, "R10 register cleared by reset", cfg_o, '0);
    load_word(LEN'(8'h5A), LEN);
    chk(cfg_o == LEN'(8'h5A), "R10 fresh word after reset", cfg_o, LEN'(8'h5A));
    chk(sen_no == 1'b0, "R10 completion after full count", LEN'(sen_no), '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule